// File: doc/BRIEF.md
# Handshaked Serial Byte Link

This block is the host end of a byte-serial link to a power-management controller. One byte moves per transfer through a shift register. The peer supplies the bit clock. An active-low request output and an active-low acknowledge input bracket every byte. Upstream logic asks for either an outgoing byte (with its data) or an incoming byte. It then waits for a done strobe, which for an incoming byte carries the received value. A timeout strobe ends the transfer instead when the peer does not respond.

The block drives the data pin only while it sends, so the data line may be shared. Both the peer clock and the acknowledge input are synchronised into the system clock, and edges of the peer clock are detected there. A transfer ends in one of two ways. If the peer lets acknowledge go high after request has been withdrawn, the transfer completes. If acknowledge stays low for a parameterised number of cycles, the transfer is abandoned.

Top module: `hsk_byte_link`

## Requirements
- R1: Out of reset, `req_n` is high, `sdat_oe`, `busy`, `done`, `timeout_err` and `ack_warn` are low, and `rx_data` is zero.
- R2: A `send_req` pulse while idle starts an outgoing byte. `busy` rises, `sdat_oe` goes high and `req_n` goes low one clock later, and `sdat_oe` holds until the transfer ends.
- R3: An outgoing byte leaves most significant bit first. Each bit is present on `sdat_o` when the peer clock rises. The output moves to the next bit only after a falling edge of the peer clock.
- R4: A `recv_req` pulse while idle starts an incoming byte with `sdat_oe` low and `req_n` low. `sdat_i` is sampled on each rising peer clock edge, most significant bit first. The assembled byte appears on `rx_data` together with `done`.
- R5: `req_n` stays low until the eighth rising peer clock edge. After that edge it returns high within a few system clocks.
- R6: After `req_n` returns high, `done` pulses for exactly one clock once the synchronised `ack_n` reads high, and never before. `busy` is low in that same cycle.
- R7: If `ack_n` stays low for TIMEOUT_CYC clocks after `req_n` returns high, `timeout_err` pulses once. In that case `done` does not pulse, the block returns to idle and `rx_data` is left unchanged.
- R8: If `ack_n` is high (not asserted) when the eighth bit completes, `ack_warn` pulses once. The transfer still finishes with `done`.
- R9: Requests that arrive while `busy` is high have no effect. When `send_req` and `recv_req` are both high in the same idle cycle, the send wins.
- R10: `rx_data` changes only in a cycle where `done` is high after an incoming byte. An outgoing byte leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_req | input | 1 | Start an outgoing byte |
| send_data | input | DATA_W | Byte to send, taken with `send_req` |
| recv_req | input | 1 | Start an incoming byte |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock strobe: byte finished |
| rx_data | output | DATA_W | Last byte received |
| timeout_err | output | 1 | One-clock strobe: acknowledge not released in time |
| ack_warn | output | 1 | One-clock strobe: acknowledge not asserted at shift end |
| sdat_o | output | 1 | Serial data towards the peer |
| sdat_oe | output | 1 | Drive enable for the serial data pin |
| sdat_i | input | 1 | Serial data from the peer |
| sclk_in | input | 1 | Shift clock supplied by the peer |
| req_n | output | 1 | Active-low transfer request |
| ack_n | input | 1 | Active-low acknowledge from the peer |

## Verification
Every one of the 256 byte values is received, then every one is sent. A bit-order or shift-direction fault therefore shows up as a wrong pattern for some value rather than hiding behind symmetric data. Each of those transfers also holds acknowledge low for a while after request returns high, which separates a correct done from one that fires on request withdrawal alone. Separate runs cover three cases: a peer that never releases acknowledge (timeout against done), a peer that never asserts it (warning with completion), and request pulses injected mid-transfer or simultaneously (ignore and priority).

// File: rtl/hsk_link_pkg.sv
package hsk_link_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SHIFT   = 2'd1,
      ST_RELEASE = 2'd2
   } link_state_e;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
   parameter int          W       = 2,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hsk_edge.sv
module hsk_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= lvl;

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/hsk_shifter.sv
module hsk_shifter #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         clear,
   input  logic         shift_en,
   input  logic         ser_in,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q,
   output logic         head
);
   logic [W-1:0] shifted;

   if (MSB_FIRST) begin : g_msb
      assign shifted = {q[W-2:0], ser_in};
      assign head    = q[W-1];
   end else begin : g_lsb
      assign shifted = {ser_in, q[W-1:1]};
      assign head    = q[0];
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        q <= '0;
      else if (load)     q <= load_val;
      else if (clear)    q <= '0;
      else if (shift_en) q <= shifted;
endmodule

// File: rtl/hsk_ack_timer.sv
module hsk_ack_timer #(
   parameter int LIMIT = 1_600_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int TW = $clog2(LIMIT + 1);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   cnt <= '0;
      else if (!run) cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;

   assign expired = run && (cnt == TW'(LIMIT - 1));
endmodule

// File: rtl/hsk_byte_link.sv
module hsk_byte_link
   import hsk_link_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 1_600_000,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_req,
   input  logic [DATA_W-1:0] send_data,
   input  logic              recv_req,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_data,
   output logic              timeout_err,
   output logic              ack_warn,
   output logic              sdat_o,
   output logic              sdat_oe,
   input  logic              sdat_i,
   input  logic              sclk_in,
   output logic              req_n,
   input  logic              ack_n
);
   localparam int CNT_W = $clog2(DATA_W);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("TIMEOUT_CYC must be at least 2");
   end

   link_state_e       state;
   logic              dir_out;
   logic              req_n_q;
   logic [CNT_W-1:0]  bitcnt;
   logic              out_bit;
   logic [DATA_W-1:0] rx_q;
   logic              done_q, tmo_q, warn_q;

   logic [1:0]        pins_s;
   logic              sclk_s, ack_s, sclk_rise, sclk_fall;
   logic              sh_load, sh_clear, sh_shift, sh_head;
   logic [DATA_W-1:0] sh_q;
   logic              expired, last_bit, first_bit;

   hsk_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ack_n, sclk_in}), .q(pins_s));

   assign sclk_s = pins_s[0];
   assign ack_s  = pins_s[1];

   hsk_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise(sclk_rise), .fall(sclk_fall));

   assign sh_load  = (state == ST_IDLE) && send_req;
   assign sh_clear = (state == ST_IDLE) && !send_req && recv_req;
   assign sh_shift = (state == ST_SHIFT) && sclk_rise;

   hsk_shifter #(.W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .clear(sh_clear),
      .shift_en(sh_shift), .ser_in(sdat_i), .load_val(send_data),
      .q(sh_q), .head(sh_head));

   hsk_ack_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(state == ST_RELEASE), .expired(expired));

   assign last_bit  = (bitcnt == CNT_W'(DATA_W - 1));
   assign first_bit = MSB_FIRST ? send_data[DATA_W-1] : send_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         dir_out <= 1'b0;
         req_n_q <= 1'b1;
         bitcnt  <= '0;
         out_bit <= 1'b0;
         rx_q    <= '0;
         done_q  <= 1'b0;
         tmo_q   <= 1'b0;
         warn_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
         warn_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (send_req) begin
                  dir_out <= 1'b1;
                  out_bit <= first_bit;
                  req_n_q <= 1'b0;
                  bitcnt  <= '0;
                  state   <= ST_SHIFT;
               end else if (recv_req) begin
                  dir_out <= 1'b0;
                  req_n_q <= 1'b0;
                  bitcnt  <= '0;
                  state   <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (sclk_fall && dir_out) out_bit <= sh_head;
               if (sclk_rise) begin
                  bitcnt <= bitcnt + 1'b1;
                  if (last_bit) begin
                     req_n_q <= 1'b1;
                     warn_q  <= ack_s;
                     state   <= ST_RELEASE;
                  end
               end
            end
            ST_RELEASE: begin
               if (ack_s) begin
                  done_q <= 1'b1;
                  if (!dir_out) rx_q <= sh_q;
                  state <= ST_IDLE;
               end else if (expired) begin
                  tmo_q <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state != ST_IDLE);
   assign done        = done_q;
   assign timeout_err = tmo_q;
   assign ack_warn    = warn_q;
   assign rx_data     = rx_q;
   assign req_n       = req_n_q;
   assign sdat_o      = out_bit;
   assign sdat_oe     = busy && dir_out;
endmodule

// File: rtl/hsk_byte_link_chk.sv
module hsk_byte_link_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] rx_data,
   input logic              timeout_err,
   input logic              sdat_oe,
   input logic              req_n
);
   assert_req_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> req_n);

   assert_oe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sdat_oe |-> busy);

   assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sdat_oe));

   assert_req_fall_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n) |-> (busy && !$past(busy)));

   assert_req_rise_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_n) |-> busy);

   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_one_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout_err));

   assert_tmo_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> !busy);

   assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> done);
endmodule

bind hsk_byte_link hsk_byte_link_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rx_data(rx_data),
   .timeout_err(timeout_err), .sdat_oe(sdat_oe), .req_n(req_n));

// File: tb/sim_hsk_byte_link.sv
module sim_hsk_byte_link;
   localparam int TMO = 40;
   localparam int H   = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       send_req = 1'b0, recv_req = 1'b0;
   logic [7:0] send_data = '0;
   logic       busy, done, timeout_err, ack_warn, sdat_o, sdat_oe, req_n;
   logic [7:0] rx_data;
   logic       sdat_i = 1'b0, sclk_in = 1'b1, ack_n = 1'b1;

   int vectors = 0, miscompares = 0;
   int done_cnt = 0, tmo_cnt = 0, warn_cnt = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hsk_byte_link #(.DATA_W(8), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO), .MSB_FIRST(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_data(send_data),
      .recv_req(recv_req), .busy(busy), .done(done), .rx_data(rx_data),
      .timeout_err(timeout_err), .ack_warn(ack_warn), .sdat_o(sdat_o),
      .sdat_oe(sdat_oe), .sdat_i(sdat_i), .sclk_in(sclk_in), .req_n(req_n),
      .ack_n(ack_n));

   always @(posedge clk) begin
      if (done)        done_cnt++;
      if (timeout_err) tmo_cnt++;
      if (ack_warn)    warn_cnt++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Start a transfer and play the peer through all eight bits.
   task automatic xfer(input bit snd, input bit both, input logic [7:0] val,
                       input bit ack_on, input bit poke, output logic [7:0] seen);
      seen = '0;
      @(negedge clk);
      send_req  = snd;
      recv_req  = !snd || both;
      send_data = val;
      @(negedge clk);
      send_req = 1'b0;
      recv_req = 1'b0;
      chk("R2 req_n low after request", int'(req_n), 0);
      chk("R2 direction (R9 send priority)", int'(sdat_oe), int'(snd));
      if (ack_on) ack_n = 1'b0;
      for (int b = 7; b >= 0; b--) begin
         sclk_in = 1'b0;
         if (!snd) sdat_i = val[b];
         if (poke && b == 4) begin
            @(negedge clk); send_req = 1'b1; recv_req = 1'b1; send_data = ~val;
            @(negedge clk); send_req = 1'b0; recv_req = 1'b0;
            repeat (H-2) @(negedge clk);
         end else begin
            repeat (H) @(negedge clk);
         end
         if (snd) seen[b] = sdat_o;
         if (b == 0) chk("R5 req_n low before last rise", int'(req_n), 0);
         sclk_in = 1'b1;
         repeat (H) @(negedge clk);
      end
      chk("R5 req_n high after last rise", int'(req_n), 1);
   endtask

   // Hold acknowledge, then release it and expect one done.
   task automatic finish_normal(input string tag);
      int d0;
      d0 = done_cnt;
      repeat (10) @(negedge clk);
      chk({tag, " R6 no done before ack release"}, done_cnt, d0);
      ack_n = 1'b1;
      repeat (8) @(negedge clk);
      chk({tag, " R6 one done after release"}, done_cnt, d0 + 1);
      chk({tag, " R6 idle after done"}, int'(busy), 0);
   endtask

   initial begin : main
      logic [7:0] seen;
      int t0, d0, w0;
      repeat (3) @(negedge clk);
      chk("R1 req_n", int'(req_n), 1);
      chk("R1 oe", int'(sdat_oe), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 strobes", int'({done, timeout_err, ack_warn}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 after release", int'({req_n, busy, sdat_oe}), 3'b100);
      chk("R1 rx_data", int'(rx_data), 0);

      // R4: every incoming value
      for (int v = 0; v < 256; v++) begin
         xfer(1'b0, 1'b0, 8'(v), 1'b1, 1'b0, seen);
         finish_normal("R4");
         chk("R4 received byte", int'(rx_data), v);
      end
      xfer(1'b0, 1'b0, 8'h5A, 1'b1, 1'b0, seen);
      finish_normal("R4");
      chk("R4 received 5A", int'(rx_data), 8'h5A);

      // R3: every outgoing value
      for (int v = 0; v < 256; v++) begin
         xfer(1'b1, 1'b0, 8'(v), 1'b1, 1'b0, seen);
         finish_normal("R3");
         chk("R3 bits seen by peer", int'(seen), v);
      end
      chk("R10 rx_data kept across sends", int'(rx_data), 8'h5A);

      // R7: acknowledge never released
      t0 = tmo_cnt; d0 = done_cnt;
      xfer(1'b0, 1'b0, 8'hC3, 1'b1, 1'b0, seen);
      repeat (TMO + 12) @(negedge clk);
      chk("R7 timeout strobe", tmo_cnt, t0 + 1);
      chk("R7 no done", done_cnt, d0);
      chk("R7 idle", int'({busy, req_n}), 2'b01);
      chk("R7 rx_data unchanged", int'(rx_data), 8'h5A);
      ack_n = 1'b1;
      repeat (4) @(negedge clk);

      // R8: acknowledge never asserted
      w0 = warn_cnt; d0 = done_cnt;
      xfer(1'b0, 1'b0, 8'h96, 1'b0, 1'b0, seen);
      repeat (8) @(negedge clk);
      chk("R8 warning strobe", warn_cnt, w0 + 1);
      chk("R8 still completes", done_cnt, d0 + 1);
      chk("R8 byte received", int'(rx_data), 8'h96);

      // R9: requests during a transfer, and both at once
      w0 = warn_cnt;
      xfer(1'b1, 1'b0, 8'hA7, 1'b1, 1'b1, seen);
      finish_normal("R9");
      chk("R9 bits unaffected by mid-transfer request", int'(seen), 8'hA7);
      repeat (4) @(negedge clk);
      chk("R9 no extra transfer", int'({busy, req_n, sdat_oe}), 3'b010);
      xfer(1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, seen);
      finish_normal("R9");
      chk("R9 send wins", int'(seen), 8'h3C);
      chk("R10 rx_data after send", int'(rx_data), 8'h96);
      chk("R8 no warning with proper ack", warn_cnt, w0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule